// File: doc/BRIEF.md
# Multi-Pattern Link Test Generator

This block sources test traffic for the transmit side of a serial link. On every clock in which it is enabled, it produces one parallel word of `W` line bits. The bits come from one of eight sources. Six are maximal-length pseudo-random sequences of order 7, 9, 13, 15, 23 and 31. The other two are a square wave with a 64-bit period and a one-zero toggle pattern. Bit 0 of each word is the bit sent first on the line. Each LFSR runs `W` steps per clock. The bits that leave it in one clock form the word.

A test harness uses the error-request input to check that a far-end checker counts errors. A request flips the first-transmitted bit of exactly one later word. The sequence itself keeps running unchanged, so the checker sees one isolated bit error and does not lose lock. A static mode input chooses how requests are recognised. In level mode every sampled high cycle is a request. In edge mode only a low-to-high change is a request. A polarity input inverts the whole output word, for links wired with swapped polarity.

Top module: `pgen_top`

## Requirements
- R1: Every LFSR obeys one rule. The next bit is the XOR of the state bits selected by its polynomial terms; bit k-1 stands for x^k. The state shifts left and the new bit enters at bit 0. That new bit is the next line bit. Word bit i carries the i-th bit produced in that clock. The state is loaded with all ones on reset and whenever the pattern selection changes.
- R2: Select code 0 gives 1+x^6+x^7 and select code 1 gives 1+x^5+x^9, both following the R1 rule.
- R3: Select code 2 gives 1+x+x^2+x^12+x^13, and its bit stream repeats with a period of exactly 8191 bits.
- R4: Select codes 3, 4 and 5 give 1+x^14+x^15, 1+x^18+x^23 and 1+x^28+x^31.
- R5: Select code 6 gives a 64-bit-period square wave: 32 ones, then 32 zeros, with the phase restarting at ones when the selection changes.
- R6: Select code 7 gives alternating bits, starting with 1 after the selection changes.
- R7: When `invert_i` is 1 at the producing edge, every bit of that word is inverted. This is applied after any error flip.
- R8: When `force_edge_i` is 0 (level mode), each edge that samples `force_err_i` high raises one error request.
- R9: When `force_edge_i` is 1 (edge mode), a request is raised only at an edge where `force_err_i` is high and was low at the previous edge.
- R10: A request flips only bit 0 of the next word produced, at or after that edge. Following words carry the unaltered sequence.
- R11: An edge with `en_i` low produces no word. At the next edge `valid_o` is 0, `data_o` holds its value, the sequence does not advance, and any outstanding request waits for the next word produced.
- R12: After reset `valid_o` and `data_o` are 0. An edge at which the selection differs from the held one reloads the source and produces no word. That edge makes `valid_o` 0 and leaves `data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sel_i | input | 3 | Pattern selection code (0 to 7) |
| en_i | input | 1 | Produce a word at this edge |
| force_err_i | input | 1 | Error request input |
| force_edge_i | input | 1 | 0: level-sensitive requests, 1: edge-sensitive requests |
| invert_i | input | 1 | Invert the output word |
| data_o | output | W | Output word, bit 0 first on the line |
| valid_o | output | 1 | `data_o` holds a new word |

## Verification
Every selection code is run with a bench model of the R1 rule and of the two fixed patterns. Mismatched taps, a wrong shift direction, bit order or seed each show up within the first words. The order-13 stream is recorded over more than one period and compared with itself shifted by 8191 bits. This finds polynomials that are not primitive as well as wrong taps. Force-error patterns cover single pulses, long held levels and requests raised while the enable is low, each in both trigger modes. Together these separate level recognition from edge recognition, show lost or duplicated flips, and show any disturbance of the running sequence.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

   localparam int unsigned LFSR_COUNT = 6;
   localparam int unsigned ORDER_MAX  = 31;

   typedef enum logic [2:0] {
      PAT_P7     = 3'd0,
      PAT_P9     = 3'd1,
      PAT_P13    = 3'd2,
      PAT_P15    = 3'd3,
      PAT_P23    = 3'd4,
      PAT_P31    = 3'd5,
      PAT_SQUARE = 3'd6,
      PAT_TOGGLE = 3'd7
   } pat_e;

   // degree of the generator polynomial for LFSR slot k
   function automatic int unsigned lfsr_order(input int unsigned k);
      case (k)
         0: return 7;
         1: return 9;
         2: return 13;
         3: return 15;
         4: return 23;
         default: return 31;
      endcase
   endfunction

   // feedback mask: bit j set means term x^(j+1)
   function automatic logic [ORDER_MAX-1:0] lfsr_taps(input int unsigned k);
      case (k)
         0: return 31'h0000_0060;
         1: return 31'h0000_0110;
         2: return 31'h0000_1803;
         3: return 31'h0000_6000;
         4: return 31'h0042_0000;
         default: return 31'h4800_0000;
      endcase
   endfunction

endpackage

// File: rtl/pgen_lfsr.sv
module pgen_lfsr #(
   parameter int unsigned ORDER = 7,
   parameter logic [ORDER-1:0] MASK = 7'h60,
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         load_i,
   input  logic         step_i,
   output logic [W-1:0] word_o
);

   if (ORDER < 2) begin : g_bad_order
      $error("pgen_lfsr: ORDER must be at least 2");
   end
   if (MASK[ORDER-1] != 1'b1) begin : g_bad_mask
      $error("pgen_lfsr: top polynomial term missing from MASK");
   end

   localparam logic [ORDER-1:0] SEED = '1;

   logic [ORDER-1:0] state_q;
   logic [ORDER-1:0] state_nx;

   always_comb begin
      logic [ORDER-1:0] s;
      logic             nb;
      s = state_q;
      word_o = '0;
      for (int i = 0; i < int'(W); i++) begin
         nb = ^(s & MASK);
         s = {s[ORDER-2:0], nb};
         word_o[i] = nb;
      end
      state_nx = s;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || load_i) begin
         state_q <= SEED;
      end else if (step_i) begin
         state_q <= state_nx;
      end
   end

   assert_state_nonzero_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (state_q != '0));

endmodule

// File: rtl/pgen_fixed.sv
module pgen_fixed #(
   parameter int unsigned W    = 16,
   parameter int unsigned HALF = 32
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         load_i,
   input  logic         step_i,
   input  logic         toggle_i,
   output logic [W-1:0] word_o
);

   localparam int unsigned PERIOD = 2 * HALF;
   localparam int unsigned PW     = $clog2(PERIOD);

   if ((HALF < 1) || ((PERIOD & (PERIOD - 1)) != 0)) begin : g_bad_half
      $error("pgen_fixed: 2*HALF must be a power of two");
   end

   logic [PW-1:0] pos_q;

   always_comb begin
      logic [PW-1:0] p;
      word_o = '0;
      for (int i = 0; i < int'(W); i++) begin
         p = pos_q + PW'(i);
         word_o[i] = toggle_i ? ~p[0] : ~p[PW-1];
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || load_i) begin
         pos_q <= '0;
      end else if (step_i) begin
         pos_q <= pos_q + PW'(W);
      end
   end

   assert_phase_restart_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> (pos_q == '0));

endmodule

// File: rtl/pgen_inject.sv
module pgen_inject (
   input  logic clk_i,
   input  logic rst_i,
   input  logic force_i,
   input  logic edge_mode_i,
   input  logic take_i,
   output logic flip_o
);

   logic force_q;
   logic pend_q;
   logic request;

   assign request = force_i && (!edge_mode_i || !force_q);
   assign flip_o  = request || pend_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         force_q <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         force_q <= force_i;
         pend_q  <= flip_o && !take_i;
      end
   end

   assert_edge_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (edge_mode_i && flip_o && force_i && take_i) |=> (!edge_mode_i || !flip_o));

   assert_level_each_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!edge_mode_i && force_i) |-> flip_o);

endmodule

// File: rtl/pgen_top.sv
module pgen_top #(
   parameter int unsigned W        = 16,
   parameter int unsigned SQ_HALF  = 32
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [2:0]   sel_i,
   input  logic         en_i,
   input  logic         force_err_i,
   input  logic         force_edge_i,
   input  logic         invert_i,
   output logic [W-1:0] data_o,
   output logic         valid_o
);
   import pgen_pkg::*;

   if (W < 1) begin : g_bad_width
      $error("pgen_top: W must be at least 1");
   end

   pat_e         sel_q;
   logic         change;
   logic         take;
   logic         flip;
   logic [W-1:0] lw [LFSR_COUNT];
   logic [W-1:0] fw;
   logic [W-1:0] raw;
   logic [W-1:0] err_mask;

   assign change = (sel_i != sel_q);
   assign take   = en_i && !change;

   for (genvar k = 0; k < LFSR_COUNT; k++) begin : g_lfsr
      localparam int unsigned      ORD = lfsr_order(k);
      localparam logic [30:0]      TAP = lfsr_taps(k);
      pgen_lfsr #(
         .ORDER (ORD),
         .MASK  (TAP[ORD-1:0]),
         .W     (W)
      ) i_lfsr (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .load_i (change),
         .step_i (take && (sel_q == pat_e'(k))),
         .word_o (lw[k])
      );
   end

   pgen_fixed #(
      .W    (W),
      .HALF (SQ_HALF)
   ) i_fixed (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_i   (change),
      .step_i   (take && (sel_q == PAT_SQUARE || sel_q == PAT_TOGGLE)),
      .toggle_i (sel_q == PAT_TOGGLE),
      .word_o   (fw)
   );

   pgen_inject i_inject (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .force_i     (force_err_i),
      .edge_mode_i (force_edge_i),
      .take_i      (take),
      .flip_o      (flip)
   );

   always_comb begin
      case (sel_q)
         PAT_P7:  raw = lw[0];
         PAT_P9:  raw = lw[1];
         PAT_P13: raw = lw[2];
         PAT_P15: raw = lw[3];
         PAT_P23: raw = lw[4];
         PAT_P31: raw = lw[5];
         default: raw = fw;
      endcase
      err_mask    = '0;
      err_mask[0] = flip;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sel_q   <= pat_e'(sel_i);
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         sel_q   <= pat_e'(sel_i);
         valid_o <= take;
         if (take) begin
            data_o <= (raw ^ err_mask) ^ {W{invert_i}};
         end
      end
   end

   assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> ($stable(data_o) && !valid_o));

   assert_reload_quiet_R12: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i != sel_q) |=> (!valid_o && $stable(data_o)));

   assert_valid_source_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> $past(en_i));

endmodule

// File: tb/test_pgen_top.sv
module test_pgen_top;

   localparam int  W     = 16;
   localparam time CLK_P = 10ns;
   localparam int  NBITS = 9600;

   logic         clk = 1'b0;
   logic         rst;
   logic [2:0]   sel_r;
   logic         en_r, frc_r, mode_r, inv_r;
   logic [W-1:0] data_o;
   logic         valid_o;

   int checks = 0;
   int errors = 0;

   logic [31:0]  m_state;
   int           m_sel, m_pos;
   bit           m_fprev, m_pend;
   logic [W-1:0] exp_data, last_clean;
   bit           exp_valid;
   bit           rec;
   int           nrec;
   bit           bits [NBITS];

   always #(CLK_P/2) clk = ~clk;

   pgen_top #(.W(W), .SQ_HALF(32)) i_pgen_top (
      .clk_i(clk), .rst_i(rst), .sel_i(sel_r), .en_i(en_r),
      .force_err_i(frc_r), .force_edge_i(mode_r), .invert_i(inv_r),
      .data_o(data_o), .valid_o(valid_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int ord_of(input int s);
      case (s) 0: return 7; 1: return 9; 2: return 13; 3: return 15; 4: return 23; default: return 31; endcase
   endfunction

   function automatic logic [31:0] taps_of(input int s);
      case (s)
         0: return 32'h60; 1: return 32'h110; 2: return 32'h1803;
         3: return 32'h6000; 4: return 32'h420000; default: return 32'h48000000;
      endcase
   endfunction

   function automatic logic [W-1:0] gen_word();
      logic [W-1:0] w;
      logic [31:0]  lm;
      bit           nb;
      lm = (m_sel < 6) ? ((32'h1 << ord_of(m_sel)) - 32'h1) : 32'h0;
      for (int i = 0; i < W; i++) begin
         if (m_sel < 6) begin
            nb = ^(m_state & taps_of(m_sel));
            m_state = ((m_state << 1) | {31'h0, nb}) & lm;
         end else if (m_sel == 6) begin
            nb = (m_pos % 64) < 32;
            m_pos++;
         end else begin
            nb = (m_pos % 2) == 0;
            m_pos++;
         end
         w[i] = nb;
      end
      return w;
   endfunction

   task automatic step(input bit en, input bit f, input bit pol, input string tag);
      bit           change, fl;
      logic [W-1:0] w;
      en_r = en; frc_r = f; inv_r = pol;
      change = (int'(sel_r) != m_sel);
      fl = (f && (!mode_r || !m_fprev)) || m_pend;
      if (change) begin
         m_sel = int'(sel_r); m_state = 32'hFFFF_FFFF; m_pos = 0;
      end
      if (en && !change) begin
         w = gen_word();
         last_clean = w;
         if (rec && nrec + W <= NBITS) begin
            for (int i = 0; i < W; i++) bits[nrec+i] = w[i];
            nrec += W;
         end
         if (fl) w[0] = ~w[0];
         if (pol) w = ~w;
         m_pend = 1'b0;
         exp_data = w;
         exp_valid = 1'b1;
      end else begin
         m_pend = fl;
         exp_valid = 1'b0;
      end
      m_fprev = f;
      @(posedge clk); #1;
      chk(valid_o === exp_valid, {tag, " valid"}, 64'(valid_o), 64'(exp_valid));
      chk(data_o === exp_data, {tag, " data"}, 64'(data_o), 64'(exp_data));
   endtask

   function automatic string tag_of(input int s);
      case (s) 0, 1: return "R2"; 2: return "R3"; 6: return "R5"; 7: return "R6"; default: return "R4"; endcase
   endfunction

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      rst = 1'b1; sel_r = 3'd0; en_r = 1'b0; frc_r = 1'b0; mode_r = 1'b0; inv_r = 1'b0;
      m_sel = 0; m_state = 32'hFFFF_FFFF; m_pos = 0; m_fprev = 0; m_pend = 0;
      exp_data = '0; rec = 0; nrec = 0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R12: reset state
      chk(valid_o === 1'b0, "R12 reset valid", 64'(valid_o), 64'(0));
      chk(data_o === '0, "R12 reset data", 64'(data_o), 64'(0));
      // R1 first word from seed, R7 polarity on code 0
      step(1, 0, 0, "R1");
      step(1, 0, 1, "R7");
      step(1, 0, 1, "R7");
      // every pattern with random enable and polarity
      for (int s = 0; s < 8; s++) begin
         sel_r = 3'(s);
         step(1, 0, 0, "R12");
         for (int n = 0; n < 40; n++)
            step(($urandom % 4) != 0, 0, $urandom % 2, tag_of(s));
      end
      // R3: period of order-13 stream
      sel_r = 3'd2;
      step(1, 0, 0, "R12");
      rec = 1;
      for (int n = 0; n < NBITS / W; n++) step(1, 0, 0, "R3");
      rec = 0;
      begin
         int bad = 0, ones = 0;
         for (int k = 0; k < NBITS - 8191; k++) if (bits[k] != bits[k+8191]) bad++;
         for (int k = 0; k < 8191; k++) ones += bits[k];
         chk(bad == 0, "R3 period mismatches", 64'(bad), 64'(0));
         chk(ones == 4096, "R3 ones per period", 64'(ones), 64'(4096));
      end
      // R8: level mode
      mode_r = 1'b0;
      sel_r = 3'd5;
      step(1, 0, 0, "R12");
      step(1, 1, 0, "R8");
      step(1, 1, 0, "R8");
      step(1, 1, 1, "R8");
      step(1, 0, 0, "R10");
      for (int n = 0; n < 60; n++) step(($urandom % 5) != 0, ($urandom % 3) == 0, $urandom % 2, "R8");
      // R9: edge mode
      step(1, 0, 0, "R9");
      mode_r = 1'b1;
      step(1, 0, 0, "R9");
      for (int n = 0; n < 4; n++) step(1, 1, 0, "R9");
      step(1, 0, 0, "R9");
      for (int n = 0; n < 60; n++) step(($urandom % 5) != 0, ($urandom % 2) == 0, $urandom % 2, "R9");
      // R10: one isolated flip on bit 0
      step(1, 0, 0, "R10");
      sel_r = 3'd4;
      step(1, 0, 0, "R12");
      step(1, 0, 0, "R10");
      step(1, 1, 0, "R10");
      chk($countones(data_o ^ last_clean) == 1 && (data_o[0] != last_clean[0]),
          "R10 single flip", 64'(data_o ^ last_clean), 64'(1));
      step(1, 1, 0, "R10");
      chk(data_o === last_clean, "R10 clean after", 64'(data_o), 64'(last_clean));
      // R11: request during idle waits for next word
      step(1, 0, 0, "R11");
      step(0, 1, 0, "R11");
      step(0, 0, 0, "R11");
      step(0, 0, 0, "R11");
      step(1, 0, 0, "R11");
      chk(data_o[0] != last_clean[0], "R11 held flip", 64'(data_o[0]), 64'(~last_clean[0]));
      step(1, 0, 0, "R11");
      // mixed random across patterns and modes
      for (int n = 0; n < 300; n++) begin
         if ((n % 50) == 0) sel_r = 3'($urandom % 8);
         step(($urandom % 4) != 0, ($urandom % 4) == 0, $urandom % 2, "R1");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule